// File: doc/BRIEF.md
# Slotted Two-Port Packet Switch with Host Injection

This block is the electronic datapath of one node in a slotted, deflection-routed network. Traffic arrives on two network inputs as a continuous stream of fixed-length slots. Each slot is a parameterised number of words, and the first word carries a full/empty flag. Each of the two output ports is a registered 4-to-1 word multiplexer. It picks one of four sources: either network input or either host transmit queue. The port's choice is made once, on the first word of a slot, and is held for every word of that slot.

An external routing controller claims output ports for through-going packets with one enable and one input-select line per port. Any port it leaves unclaimed in a slot is free for the host. Each of two host transmit queues has a steering input, which names the port it wants. It also has a broadcast input, which asks for the same packet on both ports in the same slot. A queue sends only complete packets, and only into a free slot. At the same time, each network input is watched for packets addressed to this node. Those packets are copied whole into a per-input receive queue that the host drains.

Slot framing comes from a slot-start strobe. Every output word appears one cycle after the matching input word, so the output stream keeps word alignment with the links.

Top module: `slot_switch`

## Requirements
- R1: While reset is asserted and just after it, `out_word` is zero, `out_first` is low, `tx_full` is low and `rx_avail` is low.
- R2: When `slot_start` is high with `rt_en[p]` high, output port p carries network input `rt_sel[p]` (0 = input 0, 1 = input 1) for all PKT_WORDS words of the slot. Each word appears one clock later, and `out_first` is high alongside the first word.
- R3: A transmit queue stores up to TX_DEPTH words. `tx_full[q]` is high exactly when it holds TX_DEPTH words, and a push made while it is full is discarded.
- R4: At slot start, a port with `rt_en` low is free. A non-broadcast queue holding at least PKT_WORDS words sends its oldest packet, in word order, on port `tx_pref[q]` if that port is free. Queue 0 is considered before queue 1, and each queue sends at most one packet per slot.
- R5: A queue holding fewer than PKT_WORDS words sends nothing and keeps its words.
- R6: A queue with `tx_bcast[q]` high sends only when both ports are free, and then puts the same packet on both ports in that slot. Otherwise it waits, even if its preferred port is free.
- R7: Changes to `rt_en`, `rt_sel`, `tx_pref` and `tx_bcast` after the first word of a slot have no effect on that slot.
- R8: A port with no granted source in a slot, and every port outside any slot, drives an all-zero word, so the full flag (bit WORD_W-1) reads empty.
- R9: If the first word on network input i has bit WORD_W-1 set and bits [WORD_W-2 -: ADDR_W] equal to `my_addr`, all PKT_WORDS words of that packet are written to receive queue i. `rx_data[i]` shows the oldest word while `rx_avail[i]` is high, and `rx_pop[i]` removes it.
- R10: A slot whose first word has the full bit clear, or carries another address, is not copied. A packet for which receive queue i lacks room for all PKT_WORDS words is dropped whole.
- R11: Either transmit queue can be steered to either output port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slot_start | input | 1 | High on the first word of each slot |
| net_in | input | 2 x WORD_W | Words from network inputs 0 and 1 |
| rt_en | input | 2 | Per port: routing controller claims the port for a network input |
| rt_sel | input | 2 | Per port: which network input is routed (0 or 1) |
| my_addr | input | ADDR_W | Address of this node |
| tx_push | input | 2 | Per queue: write one word into the transmit queue |
| tx_wdata | input | 2 x WORD_W | Per queue: word to write |
| tx_pref | input | 2 | Per queue: preferred output port |
| tx_bcast | input | 2 | Per queue: send the next packet on both ports |
| tx_full | output | 2 | Per queue: transmit queue full |
| rx_pop | input | 2 | Per input: remove the oldest received word |
| rx_data | output | 2 x WORD_W | Per input: oldest received word |
| rx_avail | output | 2 | Per input: receive queue holds data |
| out_word | output | 2 x WORD_W | Words on output ports 0 and 1 |
| out_first | output | 1 | High with the first output word of a slot |

## Verification
The bench goes after the held selection: it flips every control input in the middle of a slot while a host packet is waiting. A design that re-sampled its selects would splice two packets into one slot or inject into a claimed slot. Queues holding one word short of a packet and a broadcast request facing one claimed port probe the whole-packet and both-ports rules. A faulty design would emit a truncated packet or a half broadcast. Pushes into a full transmit queue and arrivals into a receive queue without room for a whole packet expose off-by-one capacity logic, which would show up as corrupted or partial packets when the queues are drained.

// File: rtl/slot_sw_pkg.sv
package slot_sw_pkg;

   typedef enum logic [1:0] {
      SRC_NET0 = 2'd0,
      SRC_NET1 = 2'd1,
      SRC_HQ0  = 2'd2,
      SRC_HQ1  = 2'd3
   } src_e;

   typedef struct packed {
      logic en;
      src_e src;
   } port_sel_t;

endpackage

// File: rtl/sw_fifo.sv
module sw_fifo #(
   parameter int W     = 16,
   parameter int DEPTH = 64
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         push,
   input  logic [W-1:0]                 wdata,
   input  logic                         pop,
   output logic [W-1:0]                 rdata,
   output logic [$clog2(DEPTH+1)-1:0]   count
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);

   if ((1 << AW) != DEPTH) begin : g_bad_depth
      $error("sw_fifo: DEPTH must be a power of two");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic          do_push, do_pop;

   assign do_push = push && (count != CW'(DEPTH));
   assign do_pop  = pop && (count != '0);
   assign rdata   = mem[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= wdata;
   end
endmodule

// File: rtl/inj_arb.sv
module inj_arb (
   input  logic [1:0] port_busy,
   input  logic [1:0] q_ready,
   input  logic [1:0] q_pref,
   input  logic [1:0] q_bcast,
   output logic [1:0] q_gnt,
   output logic [1:0] port_host,
   output logic [1:0] port_q
);
   logic [1:0] taken;

   always_comb begin
      taken     = port_busy;
      q_gnt     = '0;
      port_host = '0;
      port_q    = '0;
      for (int q = 0; q < 2; q++) begin
         if (q_ready[q]) begin
            if (q_bcast[q]) begin
               if (taken == 2'b00) begin
                  taken     = 2'b11;
                  q_gnt[q]  = 1'b1;
                  port_host = 2'b11;
                  port_q    = {1'(q), 1'(q)};
               end
            end else if (!taken[q_pref[q]]) begin
               taken[q_pref[q]]     = 1'b1;
               q_gnt[q]             = 1'b1;
               port_host[q_pref[q]] = 1'b1;
               port_q[q_pref[q]]    = 1'(q);
            end
         end
      end
   end
endmodule

// File: rtl/out_mux.sv
module out_mux
   import slot_sw_pkg::*;
#(
   parameter int W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               word_valid,
   input  port_sel_t          sel,
   input  logic [3:0][W-1:0]  src,
   output logic [W-1:0]       q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    q <= '0;
      else if (word_valid && sel.en) q <= src[sel.src];
      else                           q <= '0;
   end
endmodule

// File: rtl/slot_switch.sv
module slot_switch
   import slot_sw_pkg::*;
#(
   parameter int WORD_W    = 16,
   parameter int ADDR_W    = 3,
   parameter int PKT_WORDS = 4,
   parameter int TX_DEPTH  = 64,
   parameter int RX_DEPTH  = 64
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   slot_start,
   input  logic [1:0][WORD_W-1:0] net_in,
   input  logic [1:0]             rt_en,
   input  logic [1:0]             rt_sel,
   input  logic [ADDR_W-1:0]      my_addr,
   input  logic [1:0]             tx_push,
   input  logic [1:0][WORD_W-1:0] tx_wdata,
   input  logic [1:0]             tx_pref,
   input  logic [1:0]             tx_bcast,
   output logic [1:0]             tx_full,
   input  logic [1:0]             rx_pop,
   output logic [1:0][WORD_W-1:0] rx_data,
   output logic [1:0]             rx_avail,
   output logic [1:0][WORD_W-1:0] out_word,
   output logic                   out_first
);
   localparam int TCW = $clog2(TX_DEPTH + 1);
   localparam int RCW = $clog2(RX_DEPTH + 1);
   localparam int PW  = $clog2(PKT_WORDS + 1);
   localparam logic [TCW-1:0] TX_NEED = TCW'(PKT_WORDS);
   localparam logic [TCW-1:0] TX_MAX  = TCW'(TX_DEPTH);
   localparam logic [RCW-1:0] RX_LIM  = RCW'(RX_DEPTH - PKT_WORDS);
   localparam logic [PW-1:0]  LAST    = PW'(PKT_WORDS - 1);

   if (PKT_WORDS < 1) begin : g_bad_pkt
      $error("slot_switch: PKT_WORDS must be at least 1");
   end
   if (PKT_WORDS > TX_DEPTH || PKT_WORDS > RX_DEPTH) begin : g_bad_fit
      $error("slot_switch: a queue must hold a whole packet");
   end
   if (ADDR_W + 1 > WORD_W) begin : g_bad_addr
      $error("slot_switch: header does not fit in a word");
   end

   // slot framing
   logic          active;
   logic [PW-1:0] ph;
   logic          word_valid;

   assign word_valid = slot_start | active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         ph     <= '0;
      end else if (slot_start) begin
         active <= (PKT_WORDS > 1);
         ph     <= PW'(1);
      end else if (active) begin
         if (ph == LAST) begin
            active <= 1'b0;
            ph     <= '0;
         end else begin
            ph <= ph + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_first <= 1'b0;
      else        out_first <= slot_start;
   end

   // transmit queues
   logic [1:0][TCW-1:0]    tx_cnt;
   logic [1:0][WORD_W-1:0] tx_rdata;
   logic [1:0]             tx_pop;
   logic [1:0]             tx_ready;

   for (genvar q = 0; q < 2; q++) begin : g_tx
      sw_fifo #(.W(WORD_W), .DEPTH(TX_DEPTH)) u_fifo (
         .clk   (clk),
         .rst_n (rst_n),
         .push  (tx_push[q]),
         .wdata (tx_wdata[q]),
         .pop   (tx_pop[q]),
         .rdata (tx_rdata[q]),
         .count (tx_cnt[q])
      );
      assign tx_ready[q] = (tx_cnt[q] >= TX_NEED);
      assign tx_full[q]  = (tx_cnt[q] == TX_MAX);
   end

   // injection decision for the slot beginning now
   logic [1:0] gnt_new, gnt_hold, gnt_eff;
   logic [1:0] port_host, port_q;

   inj_arb u_arb (
      .port_busy (rt_en),
      .q_ready   (tx_ready),
      .q_pref    (tx_pref),
      .q_bcast   (tx_bcast),
      .q_gnt     (gnt_new),
      .port_host (port_host),
      .port_q    (port_q)
   );

   port_sel_t sel_new  [2];
   port_sel_t sel_hold [2];
   port_sel_t sel_eff  [2];

   always_comb begin
      for (int p = 0; p < 2; p++) begin
         if (rt_en[p]) begin
            sel_new[p].en  = 1'b1;
            sel_new[p].src = rt_sel[p] ? SRC_NET1 : SRC_NET0;
         end else if (port_host[p]) begin
            sel_new[p].en  = 1'b1;
            sel_new[p].src = port_q[p] ? SRC_HQ1 : SRC_HQ0;
         end else begin
            sel_new[p].en  = 1'b0;
            sel_new[p].src = SRC_NET0;
         end
         sel_eff[p] = slot_start ? sel_new[p] : sel_hold[p];
      end
   end

   // receive filter
   logic [1:0][RCW-1:0] rx_cnt;
   logic [1:0]          cap_new, cap_hold, cap_eff, rx_push;

   for (genvar i = 0; i < 2; i++) begin : g_rx
      assign cap_new[i] = net_in[i][WORD_W-1]
                        && (net_in[i][WORD_W-2 -: ADDR_W] == my_addr)
                        && (rx_cnt[i] <= RX_LIM);
      assign rx_push[i] = word_valid && cap_eff[i];

      sw_fifo #(.W(WORD_W), .DEPTH(RX_DEPTH)) u_fifo (
         .clk   (clk),
         .rst_n (rst_n),
         .push  (rx_push[i]),
         .wdata (net_in[i]),
         .pop   (rx_pop[i]),
         .rdata (rx_data[i]),
         .count (rx_cnt[i])
      );
      assign rx_avail[i] = (rx_cnt[i] != '0);
   end

   assign gnt_eff = slot_start ? gnt_new : gnt_hold;
   assign cap_eff = slot_start ? cap_new : cap_hold;
   assign tx_pop  = {2{word_valid}} & gnt_eff;

   // selections are locked for the rest of the slot
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gnt_hold <= '0;
         cap_hold <= '0;
         for (int p = 0; p < 2; p++) sel_hold[p] <= '0;
      end else if (slot_start) begin
         gnt_hold <= gnt_new;
         cap_hold <= cap_new;
         for (int p = 0; p < 2; p++) sel_hold[p] <= sel_new[p];
      end
   end

   // registered 4-to-1 word multiplexers
   logic [3:0][WORD_W-1:0] src_bus;
   assign src_bus = {tx_rdata[1], tx_rdata[0], net_in[1], net_in[0]};

   for (genvar p = 0; p < 2; p++) begin : g_port
      out_mux #(.W(WORD_W)) u_mux (
         .clk        (clk),
         .rst_n      (rst_n),
         .word_valid (word_valid),
         .sel        (sel_eff[p]),
         .src        (src_bus),
         .q          (out_word[p])
      );
   end
endmodule

// File: rtl/slot_switch_chk.sv
module slot_switch_chk #(
   parameter int WORD_W    = 16,
   parameter int PKT_WORDS = 4,
   parameter int TX_DEPTH  = 64,
   parameter int RX_DEPTH  = 64
) (
   input logic                                 clk,
   input logic                                 rst_n,
   input logic                                 slot_start,
   input logic                                 active,
   input logic [1:0]                           rt_en,
   input logic [1:0]                           rt_sel,
   input logic [1:0]                           tx_bcast,
   input logic [1:0]                           tx_pop,
   input logic [1:0][$clog2(TX_DEPTH+1)-1:0]   tx_cnt,
   input logic [1:0][$clog2(RX_DEPTH+1)-1:0]   rx_cnt,
   input logic [1:0][WORD_W-1:0]               net_in,
   input logic [1:0][WORD_W-1:0]               out_word
);
   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(tx_cnt[0]) <= TX_DEPTH) && (int'(tx_cnt[1]) <= TX_DEPTH));

   p_rx_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(rx_cnt[0]) <= RX_DEPTH) && (int'(rx_cnt[1]) <= RX_DEPTH));

   p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
      slot_start && rt_en[0] && !rt_sel[0] |=> out_word[0] == $past(net_in[0]));

   p_whole_pkt_r5: assert property (@(posedge clk) disable iff (!rst_n)
      slot_start && tx_pop[0] |-> int'(tx_cnt[0]) >= PKT_WORDS);

   p_bcast_same_r6: assert property (@(posedge clk) disable iff (!rst_n)
      slot_start && tx_bcast[0] && rt_en == 2'b00 && int'(tx_cnt[0]) >= PKT_WORDS
      |=> out_word[0] == out_word[1]);

   p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_start && !active |=> out_word == '0);
endmodule

bind slot_switch slot_switch_chk #(
   .WORD_W    (WORD_W),
   .PKT_WORDS (PKT_WORDS),
   .TX_DEPTH  (TX_DEPTH),
   .RX_DEPTH  (RX_DEPTH)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .slot_start (slot_start),
   .active     (active),
   .rt_en      (rt_en),
   .rt_sel     (rt_sel),
   .tx_bcast   (tx_bcast),
   .tx_pop     (tx_pop),
   .tx_cnt     (tx_cnt),
   .rx_cnt     (rx_cnt),
   .net_in     (net_in),
   .out_word   (out_word)
);

// File: tb/test_slot_switch.sv
module test_slot_switch;
   localparam int P   = 4;
   localparam int TXD = 8;
   localparam int RXD = 8;
   localparam logic [2:0] MY = 3'd5;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             slot_start = 1'b0;
   logic [1:0][15:0] net_in = '0;
   logic [1:0]       rt_en = '0, rt_sel = '0;
   logic [1:0]       tx_push = '0, tx_pref = '0, tx_bcast = '0;
   logic [1:0][15:0] tx_wdata = '0;
   logic [1:0]       tx_full, rx_pop = '0, rx_avail;
   logic [1:0][15:0] rx_data, out_word;
   logic             out_first;

   always #4 clk = ~clk;

   slot_switch #(.WORD_W(16), .ADDR_W(3), .PKT_WORDS(P),
                 .TX_DEPTH(TXD), .RX_DEPTH(RXD)) i_slot_switch (
      .clk(clk), .rst_n(rst_n), .slot_start(slot_start), .net_in(net_in),
      .rt_en(rt_en), .rt_sel(rt_sel), .my_addr(MY), .tx_push(tx_push),
      .tx_wdata(tx_wdata), .tx_pref(tx_pref), .tx_bcast(tx_bcast),
      .tx_full(tx_full), .rx_pop(rx_pop), .rx_data(rx_data),
      .rx_avail(rx_avail), .out_word(out_word), .out_first(out_first));

   int total = 0, bad = 0;
   bit done = 1'b0;
   string cur_req = "R1";

   logic [16:0] ex0[$], ex1[$];
   logic [15:0] mq0[$], mq1[$], rxm0[$], rxm1[$];
   logic [15:0] nw [2][P];

   task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // monitor: compares each port stream against the scoreboard
   always @(posedge clk) begin
      #3;
      if (ex0.size() >= 2) begin
         logic [16:0] e;
         e = ex0.pop_front();
         chk({out_first, out_word[0]} == e, cur_req, "port0",
             32'({out_first, out_word[0]}), 32'(e));
      end
      if (ex1.size() >= 2) begin
         logic [16:0] e;
         e = ex1.pop_front();
         chk({out_first, out_word[1]} == e, cur_req, "port1",
             32'({out_first, out_word[1]}), 32'(e));
      end
   end

   task automatic cyc(logic [16:0] e0, logic [16:0] e1);
      ex0.push_back(e0);
      ex1.push_back(e1);
      @(posedge clk);
      #1;
   endtask

   function automatic int qsize(int q);
      return (q == 0) ? mq0.size() : mq1.size();
   endfunction

   function automatic logic [15:0] qword(int q, int k);
      return (q == 0) ? mq0[k] : mq1[k];
   endfunction

   task automatic push_words(int q, logic [15:0] base, int n);
      for (int k = 0; k < n; k++) begin
         tx_push = '0;
         tx_push[q] = 1'b1;
         tx_wdata[q] = base + 16'(k);
         if (qsize(q) < TXD) begin
            if (q == 0) mq0.push_back(base + 16'(k));
            else        mq1.push_back(base + 16'(k));
         end
         cyc('0, '0);
      end
      tx_push = '0;
   endtask

   task automatic set_net(logic [15:0] h0, logic [15:0] h1);
      for (int k = 0; k < P; k++) begin
         nw[0][k] = h0 + ((k == 0) ? 16'd0 : 16'(k));
         nw[1][k] = h1 + ((k == 0) ? 16'd0 : 16'(k));
      end
   endtask

   // driver: one slot, expected values from the requirements
   task automatic run_slot(logic [1:0] en, logic [1:0] sel, logic [1:0] pref,
                           logic [1:0] bc, bit scramble);
      int src [2];
      logic [1:0] taken;
      logic [1:0] g;
      logic [15:0] w [2];
      taken = en;
      g = '0;
      for (int p = 0; p < 2; p++) src[p] = en[p] ? int'(sel[p]) : -1;
      for (int q = 0; q < 2; q++) begin
         if (qsize(q) >= P) begin
            if (bc[q]) begin
               if (taken == 2'b00) begin
                  src[0] = 2 + q; src[1] = 2 + q; taken = 2'b11; g[q] = 1'b1;
               end
            end else if (!taken[pref[q]]) begin
               src[pref[q]] = 2 + q; taken[pref[q]] = 1'b1; g[q] = 1'b1;
            end
         end
      end
      for (int i = 0; i < 2; i++) begin
         logic [15:0] h;
         int rs;
         h = nw[i][0];
         rs = (i == 0) ? rxm0.size() : rxm1.size();
         if (h[15] && h[14:12] == MY && rs + P <= RXD) begin
            for (int k = 0; k < P; k++) begin
               if (i == 0) rxm0.push_back(nw[0][k]);
               else        rxm1.push_back(nw[1][k]);
            end
         end
      end
      for (int k = 0; k < P; k++) begin
         slot_start = (k == 0);
         net_in[0] = nw[0][k];
         net_in[1] = nw[1][k];
         if (k == 0) begin
            rt_en = en; rt_sel = sel; tx_pref = pref; tx_bcast = bc;
         end else if (scramble) begin
            rt_en = ~en; rt_sel = ~sel; tx_pref = ~pref; tx_bcast = ~bc;
         end
         for (int p = 0; p < 2; p++) begin
            if (src[p] < 0)      w[p] = 16'h0;
            else if (src[p] < 2) w[p] = nw[src[p]][k];
            else                 w[p] = qword(src[p] - 2, k);
         end
         cyc({k == 0, w[0]}, {k == 0, w[1]});
      end
      slot_start = 1'b0; net_in = '0; rt_en = '0; rt_sel = '0;
      tx_pref = '0; tx_bcast = '0;
      for (int q = 0; q < 2; q++) begin
         if (g[q]) begin
            for (int k = 0; k < P; k++) begin
               if (q == 0) void'(mq0.pop_front());
               else        void'(mq1.pop_front());
            end
         end
      end
   endtask

   task automatic drain_rx(int i, string req);
      int n;
      n = (i == 0) ? rxm0.size() : rxm1.size();
      for (int k = 0; k < n; k++) begin
         logic [15:0] e;
         e = (i == 0) ? rxm0.pop_front() : rxm1.pop_front();
         chk(rx_avail[i] == 1'b1, req, "rx_avail while data", 32'(rx_avail[i]), 32'd1);
         chk(rx_data[i] == e, req, "rx_data", 32'(rx_data[i]), 32'(e));
         rx_pop = '0;
         rx_pop[i] = 1'b1;
         cyc('0, '0);
      end
      rx_pop = '0;
      chk(rx_avail[i] == 1'b0, req, "rx_avail after drain", 32'(rx_avail[i]), 32'd0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      chk(out_word == '0, "R1", "out_word in reset", 32'(out_word), 32'd0);
      chk(out_first == 1'b0, "R1", "out_first in reset", 32'(out_first), 32'd0);
      chk(tx_full == 2'b00, "R1", "tx_full in reset", 32'(tx_full), 32'd0);
      chk(rx_avail == 2'b00, "R1", "rx_avail in reset", 32'(rx_avail), 32'd0);
      rst_n = 1'b1;
      cyc('0, '0);
      cyc('0, '0);

      // R2: through-going traffic, crossed and shared selects
      cur_req = "R2";
      set_net(16'h9010, 16'h9120);
      run_slot(2'b11, 2'b01, 2'b00, 2'b00, 1'b0);
      set_net(16'h9230, 16'h9340);
      run_slot(2'b11, 2'b10, 2'b00, 2'b00, 1'b0);
      set_net(16'h9450, 16'h0000);
      run_slot(2'b11, 2'b00, 2'b00, 2'b00, 1'b0);

      // R8: no claim and nothing queued gives empty words
      cur_req = "R8";
      set_net(16'h9560, 16'h9670);
      run_slot(2'b00, 2'b00, 2'b00, 2'b00, 1'b0);
      cyc('0, '0);

      // R5: a short queue stays put, then completes and goes out (R4)
      cur_req = "R5";
      push_words(0, 16'h5000, P - 1);
      set_net(16'h0000, 16'h0000);
      run_slot(2'b00, 2'b00, 2'b00, 2'b00, 1'b0);
      cur_req = "R4";
      push_words(0, 16'h5000 + 16'(P - 1), 1);
      set_net(16'h9780, 16'h9890);
      run_slot(2'b10, 2'b10, 2'b00, 2'b00, 1'b0);
      cyc('0, '0);

      // R11: queue 0 to port 1, queue 1 to port 0
      cur_req = "R11";
      push_words(0, 16'h6100, P);
      push_words(1, 16'h6200, P);
      set_net(16'h0000, 16'h0000);
      run_slot(2'b00, 2'b00, 2'b01, 2'b00, 1'b0);

      // R4: both prefer port 0, queue 0 first, queue 1 next slot
      cur_req = "R4";
      push_words(0, 16'h6300, P);
      push_words(1, 16'h6400, P);
      run_slot(2'b00, 2'b00, 2'b00, 2'b00, 1'b0);
      run_slot(2'b00, 2'b00, 2'b00, 2'b00, 1'b0);
      chk(mq0.size() == 0 && mq1.size() == 0, "R4", "model queues drained",
          32'(mq0.size() + mq1.size()), 32'd0);

      // R6: broadcast blocked by one claimed port, then sent on both
      cur_req = "R6";
      push_words(0, 16'h6500, P);
      set_net(16'h0000, 16'h9AB0);
      run_slot(2'b10, 2'b11, 2'b00, 2'b01, 1'b0);
      set_net(16'h0000, 16'h0000);
      run_slot(2'b00, 2'b00, 2'b00, 2'b01, 1'b0);

      // R7: controls flipped mid-slot with a host packet waiting
      cur_req = "R7";
      push_words(0, 16'h6600, P);
      set_net(16'h9C00, 16'h9D00);
      run_slot(2'b11, 2'b10, 2'b00, 2'b00, 1'b1);
      set_net(16'h0000, 16'h0000);
      run_slot(2'b00, 2'b00, 2'b00, 2'b00, 1'b0);

      // R3: overfill queue 0, extra word discarded
      cur_req = "R3";
      push_words(0, 16'h7000, TXD + 1);
      chk(tx_full[0] == 1'b1, "R3", "tx_full at depth", 32'(tx_full[0]), 32'd1);
      chk(tx_full[1] == 1'b0, "R3", "other queue not full", 32'(tx_full[1]), 32'd0);
      run_slot(2'b00, 2'b00, 2'b00, 2'b00, 1'b0);
      chk(tx_full[0] == 1'b0, "R3", "tx_full after send", 32'(tx_full[0]), 32'd0);
      run_slot(2'b00, 2'b00, 2'b00, 2'b00, 1'b0);
      run_slot(2'b00, 2'b00, 2'b00, 2'b00, 1'b0);
      cyc('0, '0);

      // R9/R10: receive filter and whole-packet drop
      cur_req = "R9";
      set_net(16'hD001, 16'h5100);
      run_slot(2'b00, 2'b00, 2'b00, 2'b00, 1'b0);
      chk(rx_avail[1] == 1'b0, "R10", "empty slot not copied", 32'(rx_avail[1]), 32'd0);
      set_net(16'hD100, 16'hA200);
      run_slot(2'b00, 2'b00, 2'b00, 2'b00, 1'b0);
      chk(rx_avail[1] == 1'b0, "R10", "other address not copied", 32'(rx_avail[1]), 32'd0);
      cur_req = "R10";
      set_net(16'hD200, 16'hD300);
      run_slot(2'b00, 2'b00, 2'b00, 2'b00, 1'b0);
      cyc('0, '0);
      drain_rx(0, "R10");
      drain_rx(1, "R9");

      cyc('0, '0);
      cyc('0, '0);
      cyc('0, '0);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule